// File: doc/BRIEF.md
# Address-Compare Loop Cache Steering Controller

This controller sits beside a pipelined instruction fetch bus and decides, for every fetch, whether the word comes from main instruction memory or from a small loop buffer of 2^W words. It has no view of the decoder or of branch outcomes. Loops are recognised only from the stream of fetch addresses. A fetch counts only when the transfer-active bit and the instruction-access bit are both high. The controller keeps the previous counted address and compares each new fetch with it. When a fetch lands a short distance below the previous one, a tight loop has closed once. The controller records where the loop starts and ends and fills the buffer during the next pass. From the pass after that it serves the loop from the buffer.

The controller cannot see a jump until the target address is already on the bus. To cover that delay, the source select, the buffer write enable and the memory enables are decided combinationally from the current fetch. The mode register only moves on the following clock edge. The buffer writes in the data phase, so its write index is the low bits of the registered previous address. A global enable lets software keep every fetch on main memory while the controller keeps tracking loops.

Top module: `loop_steer`

## Requirements
- R1: After reset (active-low `rst_n`) the controller is in its idle mode: `src_main`=1, `buf_we`=0, and no earlier address is held, so the first counted fetch cannot start a loop.
- R2: A fetch counts only when `xfer_active`=1 and `instr_access`=1. An uncounted cycle does not change the mode and does not replace the stored previous address.
- R3: In idle, a counted fetch whose address is below the previous counted address by 1 to 2^W-1 words starts filling. `buf_we`=1 in that same cycle, and the fill mode holds from the next edge. A forward jump, or a backward jump of 2^W words or more, does not start filling.
- R4: While filling, each counted fetch at previous+1 whose previous address is not the recorded loop end gives `buf_we`=1 and `src_main`=1.
- R5: While filling, a counted fetch of the recorded loop start right after the recorded loop end gives `src_main`=0 and `buf_we`=0 in that same cycle. The buffer-serving mode holds from the next edge. That mode is entered only from filling.
- R6: While serving, sequential fetches inside the loop and the jump from loop end back to loop start keep `src_main`=0.
- R7: While filling or serving, any other counted fetch leaves the loop. This covers falling through past the loop end and any jump that is not end-to-start. In that cycle `src_main`=1 and `buf_we`=0, and idle holds from the next edge.
- R8: `buf_widx` equals the low W bits of the most recent counted fetch address before the current cycle.
- R9: `main_en` = `xfer_active` AND (NOT `glob_en` OR `src_main`). `buf_en` = `xfer_active` AND `glob_en` AND NOT `src_main`. The two are never high together.
- R10: `buf_we` is 0 in every cycle without a counted fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_addr | input | AW | Word address of the fetch in its address phase |
| xfer_active | input | 1 | Transfer-active bit of the fetch bus |
| instr_access | input | 1 | Access is an instruction fetch |
| glob_en | input | 1 | Global buffer enable from software |
| buf_we | output | 1 | Store the word fetched in this cycle into the buffer |
| buf_widx | output | W | Buffer index for the data-phase write |
| src_main | output | 1 | Read multiplexer select: 1 main memory, 0 buffer |
| main_en | output | 1 | Main instruction memory enable |
| buf_en | output | 1 | Loop buffer read enable |

## Verification
The assertions check these rules on every cycle:
- the enables are exclusive and follow the global enable and transfer bits;
- no write happens without a counted fetch, and a write never coincides with a buffer read;
- uncounted cycles leave the mode unchanged;
- the write index tracks the last counted address;
- the serving mode is reached only from filling, and any main-memory fetch while serving returns the controller to idle.

Only the directed scenarios can show:
- the exact cycle in which `src_main` drops on the closing jump;
- the distance limit at 2^W-1 against 2^W words;
- exits by fall-through and by foreign jumps;
- a stray uncounted address inside a running loop leaving both the mode and the comparison untouched.

// File: rtl/lsc_pkg.sv
// Shared types for the loop cache steering controller.
package lsc_pkg;

    // Operating mode of the loop controller.
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FILL   = 2'd1,
        ST_ACTIVE = 2'd2
    } lsc_state_e;

endpackage

// File: rtl/lsc_addr_track.sv
// Address tracker: holds the previous counted fetch address and classifies
// the current fetch against it as sequential or as a short backward jump.
// Assumes word addresses and W < AW.
module lsc_addr_track #(
    parameter int AW = 16,
    parameter int W  = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fetch_ok,
    input  logic [AW-1:0] addr,
    output logic [AW-1:0] prev,
    output logic          is_seq,
    output logic          is_short_back
);
    logic          prev_valid;
    logic [AW-1:0] back_dist;

    // Record the address of every counted fetch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev       <= '0;
            prev_valid <= 1'b0;
        end else if (fetch_ok) begin
            prev       <= addr;
            prev_valid <= 1'b1;
        end
    end

    // Compare the current address with the stored one.
    always_comb begin
        back_dist     = prev - addr;
        is_seq        = prev_valid && (addr == prev + AW'(1));
        is_short_back = prev_valid && (addr < prev) && (back_dist[AW-1:W] == '0);
    end

endmodule

// File: rtl/lsc_mode_fsm.sv
// Mode controller: idle/fill/active sequence. Records the loop bounds when
// a short backward jump appears in idle. Decides source select and buffer
// write for the current fetch combinationally. The mode register moves on
// the next edge. Assumes the classification inputs come from the tracker.
module lsc_mode_fsm
    import lsc_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fetch_ok,
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] prev,
    input  logic          is_seq,
    input  logic          is_short_back,
    output lsc_state_e    state,
    output logic          src_main,
    output logic          buf_we
);
    lsc_state_e    nxt;
    logic [AW-1:0] loop_head;
    logic [AW-1:0] loop_tail;
    logic          at_tail;
    logic          to_head;
    logic          in_loop;

    // Position of the current fetch relative to the recorded loop.
    always_comb begin
        at_tail = (prev == loop_tail);
        to_head = (addr == loop_head);
        in_loop = (is_seq && !at_tail) || (at_tail && to_head);
    end

    // Next mode and per-fetch outputs.
    always_comb begin
        nxt      = state;
        buf_we   = 1'b0;
        src_main = (state != ST_ACTIVE);
        if (fetch_ok) begin
            unique case (state)
                ST_IDLE: begin
                    if (is_short_back) begin
                        nxt    = ST_FILL;
                        buf_we = 1'b1;
                    end
                end
                ST_FILL: begin
                    if (is_seq && !at_tail) begin
                        buf_we = 1'b1;
                    end else if (at_tail && to_head) begin
                        nxt      = ST_ACTIVE;
                        src_main = 1'b0;
                    end else begin
                        nxt = ST_IDLE;
                    end
                end
                ST_ACTIVE: begin
                    if (in_loop) begin
                        src_main = 1'b0;
                    end else begin
                        nxt      = ST_IDLE;
                        src_main = 1'b1;
                    end
                end
                default: nxt = ST_IDLE;
            endcase
        end
    end

    // Mode register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Capture loop bounds when a fill starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            loop_head <= '0;
            loop_tail <= '0;
        end else if (fetch_ok && state == ST_IDLE && is_short_back) begin
            loop_head <= addr;
            loop_tail <= prev;
        end
    end

endmodule

// File: rtl/lsc_enable_gen.sv
// Memory enable generation from source select, global enable and the
// transfer-active bit. Pure combinational.
module lsc_enable_gen (
    input  logic xfer_active,
    input  logic glob_en,
    input  logic src_main,
    output logic main_en,
    output logic buf_en
);
    logic use_main;

    // Main memory unless software enabled the buffer and the buffer is selected.
    always_comb begin
        use_main = !glob_en || src_main;
        main_en  = xfer_active && use_main;
        buf_en   = xfer_active && !use_main;
    end

endmodule

// File: rtl/loop_steer.sv
// Top of the loop cache steering controller. Counts fetches from the
// transfer and instruction bits, tracks addresses, and runs the mode
// controller and the enable generation. The buffer array and the memory
// sit outside this block.
module loop_steer
    import lsc_pkg::*;
#(
    parameter int AW = 16,
    parameter int W  = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] fetch_addr,
    input  logic          xfer_active,
    input  logic          instr_access,
    input  logic          glob_en,
    output logic          buf_we,
    output logic [W-1:0]  buf_widx,
    output logic          src_main,
    output logic          main_en,
    output logic          buf_en
);
    logic          fetch_ok;
    logic [AW-1:0] prev;
    logic          is_seq;
    logic          is_short_back;
    lsc_state_e    cur_state;

    // A fetch counts only with both qualifying bits.
    always_comb fetch_ok = xfer_active && instr_access;

    lsc_addr_track #(.AW(AW), .W(W)) u_track (
        .clk           (clk),
        .rst_n         (rst_n),
        .fetch_ok      (fetch_ok),
        .addr          (fetch_addr),
        .prev          (prev),
        .is_seq        (is_seq),
        .is_short_back (is_short_back)
    );

    lsc_mode_fsm #(.AW(AW)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .fetch_ok      (fetch_ok),
        .addr          (fetch_addr),
        .prev          (prev),
        .is_seq        (is_seq),
        .is_short_back (is_short_back),
        .state         (cur_state),
        .src_main      (src_main),
        .buf_we        (buf_we)
    );

    lsc_enable_gen u_en (
        .xfer_active (xfer_active),
        .glob_en     (glob_en),
        .src_main    (src_main),
        .main_en     (main_en),
        .buf_en      (buf_en)
    );

    // The delayed address doubles as the data-phase write index.
    always_comb buf_widx = prev[W-1:0];

endmodule

// File: rtl/loop_steer_chk.sv
// Checker for loop_steer, attached by bind.
module loop_steer_chk
    import lsc_pkg::*;
#(
    parameter int AW = 16,
    parameter int W  = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] fetch_addr,
    input logic          xfer_active,
    input logic          instr_access,
    input logic          glob_en,
    input logic          buf_we,
    input logic [W-1:0]  buf_widx,
    input logic          src_main,
    input logic          main_en,
    input logic          buf_en,
    input lsc_state_e    cur_state
);
    // R10
    no_unqual_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(xfer_active && instr_access) |-> !buf_we);

    // R9
    enable_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(main_en && buf_en));

    // R9
    idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_active |-> (!main_en && !buf_en));

    // R9
    global_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_active && !glob_en) |-> main_en);

    // R8
    widx_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_active && instr_access) |=> (buf_widx == $past(fetch_addr[W-1:0])));

    // R4
    write_from_main_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we |-> src_main);

    // R2
    hold_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(xfer_active && instr_access) |=> (cur_state == $past(cur_state)));

    // R5
    active_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_state == ST_ACTIVE && $past(cur_state) != ST_ACTIVE) |-> ($past(cur_state) == ST_FILL));

    // R7
    active_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_state == ST_ACTIVE && src_main) |=> (cur_state == ST_IDLE));

endmodule

bind loop_steer loop_steer_chk #(.AW(AW), .W(W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .fetch_addr   (fetch_addr),
    .xfer_active  (xfer_active),
    .instr_access (instr_access),
    .glob_en      (glob_en),
    .buf_we       (buf_we),
    .buf_widx     (buf_widx),
    .src_main     (src_main),
    .main_en      (main_en),
    .buf_en       (buf_en),
    .cur_state    (cur_state)
);

// File: tb/loop_steer_test.sv
// Directed bench for loop_steer: one task per scenario.
module loop_steer_test;
    localparam int AW = 16;
    localparam int W  = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] fetch_addr = '0;
    logic          xfer_active = 1'b0;
    logic          instr_access = 1'b0;
    logic          glob_en = 1'b1;
    logic          buf_we;
    logic [W-1:0]  buf_widx;
    logic          src_main;
    logic          main_en;
    logic          buf_en;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    loop_steer #(.AW(AW), .W(W)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .fetch_addr   (fetch_addr),
        .xfer_active  (xfer_active),
        .instr_access (instr_access),
        .glob_en      (glob_en),
        .buf_we       (buf_we),
        .buf_widx     (buf_widx),
        .src_main     (src_main),
        .main_en      (main_en),
        .buf_en       (buf_en)
    );

    always #5 clk = ~clk;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Drive one fetch after the falling edge; outputs are settled 2 ns later.
    task automatic fetch(input int a, input bit x, input bit i);
        @(negedge clk);
        fetch_addr   = AW'(a);
        xfer_active  = x;
        instr_access = i;
        #2;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        xfer_active = 1'b0;
        instr_access = 1'b0;
        glob_en = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset_state();
        do_reset();
        xfer_active = 1'b1;
        #1;
        chk("R1", "src_main", int'(src_main), 1);
        chk("R1", "buf_we", int'(buf_we), 0);
        chk("R9", "main_en after reset", int'(main_en), 1);
        chk("R9", "buf_en after reset", int'(buf_en), 0);
        xfer_active = 1'b0;
    endtask

    task automatic t_basic_loop();
        do_reset();
        for (int a = 100; a <= 103; a++) begin
            fetch(a, 1, 1);
            chk("R1", "no write before a loop", int'(buf_we), 0);
        end
        fetch(100, 1, 1);
        chk("R3", "trigger write", int'(buf_we), 1);
        chk("R3", "trigger src", int'(src_main), 1);
        for (int a = 101; a <= 103; a++) begin
            fetch(a, 1, 1);
            chk("R4", "fill write", int'(buf_we), 1);
            chk("R4", "fill src", int'(src_main), 1);
            chk("R8", "write index", int'(buf_widx), (a - 1) % 8);
        end
        fetch(100, 1, 1);
        chk("R5", "close src", int'(src_main), 0);
        chk("R5", "close write", int'(buf_we), 0);
        chk("R9", "buf_en serving", int'(buf_en), 1);
        chk("R9", "main_en serving", int'(main_en), 0);
        for (int p = 0; p < 2; p++) begin
            for (int a = 101; a <= 103; a++) begin
                fetch(a, 1, 1);
                chk("R6", "serving seq src", int'(src_main), 0);
            end
            if (p == 0) begin
                fetch(100, 1, 1);
                chk("R6", "serving loopback src", int'(src_main), 0);
            end
        end
        fetch(104, 1, 1);
        chk("R7", "fall-through src", int'(src_main), 1);
        chk("R7", "fall-through main_en", int'(main_en), 1);
        fetch(105, 1, 1);
        chk("R7", "idle after exit write", int'(buf_we), 0);
        chk("R7", "idle after exit src", int'(src_main), 1);
    endtask

    task automatic t_distance();
        do_reset();
        for (int a = 300; a <= 307; a++) fetch(a, 1, 1);
        fetch(300, 1, 1);
        chk("R3", "jump back 7 triggers", int'(buf_we), 1);
        do_reset();
        fetch(400, 1, 1);
        fetch(392, 1, 1);
        chk("R3", "jump back 8 ignored", int'(buf_we), 0);
        fetch(393, 1, 1);
        chk("R3", "no fill after long jump", int'(buf_we), 0);
        fetch(420, 1, 1);
        chk("R3", "forward jump ignored", int'(buf_we), 0);
        fetch(421, 1, 1);
        chk("R3", "no fill after forward jump", int'(buf_we), 0);
    endtask

    task automatic t_fill_abort();
        do_reset();
        fetch(50, 1, 1);
        fetch(51, 1, 1);
        fetch(52, 1, 1);
        fetch(50, 1, 1);
        fetch(51, 1, 1);
        chk("R4", "fill write", int'(buf_we), 1);
        fetch(70, 1, 1);
        chk("R7", "foreign jump write", int'(buf_we), 0);
        chk("R7", "foreign jump src", int'(src_main), 1);
        fetch(71, 1, 1);
        chk("R7", "idle after abort", int'(buf_we), 0);
    endtask

    task automatic t_unqualified();
        do_reset();
        fetch(10, 1, 1);
        fetch(11, 1, 1);
        fetch(12, 1, 1);
        fetch(10, 1, 1);
        fetch(11, 1, 1);
        fetch(12, 1, 1);
        fetch(10, 1, 1);
        chk("R5", "serving entered", int'(src_main), 0);
        fetch(900, 1, 0);
        chk("R10", "no write uncounted", int'(buf_we), 0);
        chk("R2", "uncounted keeps serving", int'(src_main), 0);
        fetch(11, 1, 1);
        chk("R2", "loop continues after stray", int'(src_main), 0);
        chk("R8", "index unaffected by stray", int'(buf_widx), 10 % 8);
        do_reset();
        fetch(20, 1, 1);
        fetch(21, 1, 1);
        fetch(22, 1, 1);
        fetch(15, 0, 1);
        chk("R10", "no write idle bus", int'(buf_we), 0);
        chk("R9", "no enables idle bus", int'(main_en) + int'(buf_en), 0);
        fetch(23, 1, 1);
        chk("R2", "stray backward address did not trigger", int'(buf_we), 0);
        chk("R8", "index after stray", int'(buf_widx), 22 % 8);
    endtask

    task automatic t_global();
        do_reset();
        glob_en = 1'b0;
        fetch(60, 1, 1);
        fetch(61, 1, 1);
        fetch(60, 1, 1);
        fetch(61, 1, 1);
        fetch(60, 1, 1);
        chk("R9", "global off keeps main", int'(main_en), 1);
        chk("R9", "global off no buffer", int'(buf_en), 0);
        glob_en = 1'b1;
        fetch(61, 1, 1);
        chk("R9", "global on uses buffer", int'(buf_en), 1);
        chk("R9", "global on main off", int'(main_en), 0);
    endtask

    initial begin
        t_reset_state();
        t_basic_loop();
        t_distance();
        t_fill_abort();
        t_unqualified();
        t_global();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule